// File: doc/BRIEF.md
# Processor Reset Generator with Cause Log

This block drives power-on-style and externally-initiated resets to four processors and remembers why the most recent reset of each kind happened. Software requests resets by writing byte-wide control registers. External requests come from several inputs: a watchdog-expired line, a reset push-button, an XIR push-button, JTAG reset and JTAG XIR requests, a remote-monitor reset request and seven fatal-error inputs. Each request becomes a fixed-length pulse on a per-processor reset output. A system reset also raises a separate whole-system pulse.

Every reset event replaces the contents of a read-only 18-bit POR cause log with the causes seen in that cycle. XIR events update a separate 6-bit XIR cause log in the same way. Fatal-error inputs 0 to 3 can be masked. The watchdog line and the clock-synthesizer load write only cause a system reset when their enable bits are set. The synchronous reset input is the power-up indication, and it leaves the power-up bit set in the POR cause log.

Reads are registered: `rd_data` holds the byte at `rd_addr` from one clock earlier. External inputs act on their rising edge.

Top module: `reset_cause_ctl`

## Requirements
- R1: After reset all reset outputs are low. The POR cause log reads 0x80 at offset 0x8 and 0x00 at offsets 0x9 and 0xA. The XIR cause log (offset 0xC), watchdog control (0x0), mask (0x3) and synthesizer control (0x4) all read 0x00.
- R2: Writing offset 0x1 with bits 3:0 = v raises `por_o` = v for exactly 8 cycles, starting the cycle after the write. The POR cause log becomes v in bits 3:0. Offset 0x1 reads 0x00 afterwards.
- R3: Writing offset 0x1 with bit 4 set raises `sys_rst_o` and all four `por_o` bits for 8 cycles, and sets POR log bit 4.
- R4: Writing offset 0x2 with bits 3:0 = v raises `xir_o` = v for 8 cycles and sets the XIR log to v. Offset 0x2 reads 0x00 afterwards. The POR log is not changed.
- R5: A rising edge on `jtag_xir_i` raises all `xir_o` bits for 8 cycles and sets the XIR log to 0x10. A rising edge on `xir_btn_i` does the same and sets the XIR log to 0x20.
- R6: When bit 0 of offset 0x0 is 1, a rising edge on `wdog_i` causes a system reset and sets POR log bit 16. When that bit is 0, the watchdog line has no effect on the outputs or on the log.
- R7: Rising edges on `jtag_rst_i`, `por_btn_i` and `rmon_i` each cause a system reset and set POR log bit 5, 6 or 17 respectively.
- R8: A rising edge on `fatal_i[i]` causes a system reset and sets POR log bit 8+i. For i = 0 to 3 this happens only if bit 4+i of offset 0x3 is 0. A masked input neither resets nor touches the log.
- R9: A write to offset 0x4 with both bit 0 and bit 7 set causes a system reset and sets POR log bit 15. If either bit is 0, the write causes no reset. Offset 0x4 reads back bits 7 and 0.
- R10: Each reset event clears the POR log and loads all causes present in that cycle. Writes to the log offsets 0x8 to 0xA are ignored.
- R11: A new request for an output that is already pulsing restarts its 8-cycle count.
- R12: An external input held high produces only one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 8 | Registered read data |
| wdog_i | input | 1 | Watchdog expired |
| jtag_rst_i | input | 1 | JTAG system reset request |
| jtag_xir_i | input | 1 | JTAG XIR request |
| por_btn_i | input | 1 | Reset push-button |
| xir_btn_i | input | 1 | XIR push-button |
| rmon_i | input | 1 | Remote-monitor reset request |
| fatal_i | input | 7 | Fatal-error inputs |
| por_o | output | 4 | Per-processor POR pulses |
| xir_o | output | 4 | Per-processor XIR pulses |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The bench runs every 4-bit soft POR and soft XIR pattern. Each run measures which outputs rise and how long they stay high, so a swapped bit or a wrong length is caught.

The bench also crosses all 16 mask settings with all seven fatal inputs. This separates a masked input from an unmasked one and catches an off-by-one in the mask position.

Each external source is pulsed alone so that the bit it sets in the log can be identified. The watchdog and synthesizer sources are also pulsed with their enables off. Held inputs, retriggers mid-pulse and writes to the read-only log probe edge detection, count restart and clear-and-load.

// File: rtl/reset_cause_pkg.sv
package reset_cause_pkg;
  localparam int NCPU   = 4;
  localparam int NFATAL = 7;
  localparam int NMASK  = 4;
  localparam int POR_W  = 18;
  localparam int XIR_W  = 6;

  // register offsets
  localparam logic [3:0] OFS_WDOG  = 4'h0;
  localparam logic [3:0] OFS_SPOR  = 4'h1;
  localparam logic [3:0] OFS_SXIR  = 4'h2;
  localparam logic [3:0] OFS_MASK  = 4'h3;
  localparam logic [3:0] OFS_SYNTH = 4'h4;
  localparam logic [3:0] OFS_PLOG0 = 4'h8;
  localparam logic [3:0] OFS_PLOG1 = 4'h9;
  localparam logic [3:0] OFS_PLOG2 = 4'hA;
  localparam logic [3:0] OFS_XLOG  = 4'hC;

  // POR log bit positions
  localparam int PB_SYS  = 4;
  localparam int PB_JTAG = 5;
  localparam int PB_BTN  = 6;
  localparam int PB_PWR  = 7;
  localparam int PB_FE0  = 8;
  localparam int PB_SYN  = 15;
  localparam int PB_WDT  = 16;
  localparam int PB_RMON = 17;

  // XIR log bit positions
  localparam int XB_JTAG = 4;
  localparam int XB_BTN  = 5;

  // external input vector order
  localparam int EX_WDOG = 0;
  localparam int EX_JRST = 1;
  localparam int EX_JXIR = 2;
  localparam int EX_PBTN = 3;
  localparam int EX_XBTN = 4;
  localparam int EX_RMON = 5;
  localparam int EX_W    = 6;
endpackage

// File: rtl/reset_cause_edge.sv
module reset_cause_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/reset_cause_pulse.sv
module reset_cause_pulse #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic pulse
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= 1'b0;
      cnt_q <= '0;
    end else if (trig) begin
      pulse <= 1'b1;
      cnt_q <= CW'(LEN - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else begin
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/reset_cause_ctl.sv
module reset_cause_ctl
  import reset_cause_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int PULSE_LEN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              wdog_i,
  input  logic              jtag_rst_i,
  input  logic              jtag_xir_i,
  input  logic              por_btn_i,
  input  logic              xir_btn_i,
  input  logic              rmon_i,
  input  logic [NFATAL-1:0] fatal_i,
  output logic [NCPU-1:0]   por_o,
  output logic [NCPU-1:0]   xir_o,
  output logic              sys_rst_o
);
  logic              wd_en;
  logic [NMASK-1:0]  fe_mask;
  logic              syn_load, syn_rst;
  logic [POR_W-1:0]  por_log;
  logic [XIR_W-1:0]  xir_log;

  logic [EX_W-1:0]   ex_rise;
  logic [NFATAL-1:0] fe_rise;
  logic [POR_W-1:0]  por_cause;
  logic [XIR_W-1:0]  xir_cause;
  logic              sys_evt, xir_all;
  logic [NCPU-1:0]   por_trig, xir_trig;

  logic wr_spor, wr_sxir, wr_wdog, wr_mask, wr_synth;
  assign wr_spor  = wr_en && (wr_addr == ADDR_W'(OFS_SPOR));
  assign wr_sxir  = wr_en && (wr_addr == ADDR_W'(OFS_SXIR));
  assign wr_wdog  = wr_en && (wr_addr == ADDR_W'(OFS_WDOG));
  assign wr_mask  = wr_en && (wr_addr == ADDR_W'(OFS_MASK));
  assign wr_synth = wr_en && (wr_addr == ADDR_W'(OFS_SYNTH));

  reset_cause_edge #(.W(EX_W)) u_ex_edge (
    .clk (clk), .rst (rst),
    .lvl ({rmon_i, xir_btn_i, por_btn_i, jtag_xir_i, jtag_rst_i, wdog_i}),
    .rise(ex_rise)
  );

  reset_cause_edge #(.W(NFATAL)) u_fe_edge (
    .clk (clk), .rst (rst), .lvl (fatal_i), .rise(fe_rise)
  );

  // cause vectors for this cycle
  always_comb begin
    por_cause = '0;
    if (wr_spor) begin
      por_cause[NCPU-1:0] = wr_data[NCPU-1:0];
      por_cause[PB_SYS]   = wr_data[NCPU];
    end
    por_cause[PB_JTAG] = ex_rise[EX_JRST];
    por_cause[PB_BTN]  = ex_rise[EX_PBTN];
    por_cause[PB_FE0 +: NFATAL] =
      fe_rise & ~{{(NFATAL-NMASK){1'b0}}, fe_mask};
    por_cause[PB_SYN]  = wr_synth && wr_data[0] && wr_data[7];
    por_cause[PB_WDT]  = ex_rise[EX_WDOG] && wd_en;
    por_cause[PB_RMON] = ex_rise[EX_RMON];

    xir_cause = '0;
    if (wr_sxir) xir_cause[NCPU-1:0] = wr_data[NCPU-1:0];
    xir_cause[XB_JTAG] = ex_rise[EX_JXIR];
    xir_cause[XB_BTN]  = ex_rise[EX_XBTN];
  end

  assign sys_evt = |por_cause[POR_W-1:PB_SYS];
  assign xir_all = |xir_cause[XIR_W-1:NCPU];

  // control registers and logs
  always_ff @(posedge clk) begin
    if (rst) begin
      wd_en    <= 1'b0;
      fe_mask  <= '0;
      syn_load <= 1'b0;
      syn_rst  <= 1'b0;
      por_log  <= POR_W'(1) << PB_PWR;
      xir_log  <= '0;
    end else begin
      if (wr_wdog)  wd_en   <= wr_data[0];
      if (wr_mask)  fe_mask <= wr_data[7 -: NMASK];
      if (wr_synth) begin
        syn_load <= wr_data[0];
        syn_rst  <= wr_data[7];
      end
      if (|por_cause) por_log <= por_cause;
      if (|xir_cause) xir_log <= xir_cause;
    end
  end

  // pulse generators
  genvar gi;
  generate
    for (gi = 0; gi < NCPU; gi++) begin : g_cpu
      assign por_trig[gi] = por_cause[gi] | sys_evt;
      assign xir_trig[gi] = xir_cause[gi] | xir_all;

      reset_cause_pulse #(.LEN(PULSE_LEN)) u_por (
        .clk(clk), .rst(rst), .trig(por_trig[gi]), .pulse(por_o[gi])
      );
      reset_cause_pulse #(.LEN(PULSE_LEN)) u_xir (
        .clk(clk), .rst(rst), .trig(xir_trig[gi]), .pulse(xir_o[gi])
      );
    end
  endgenerate

  reset_cause_pulse #(.LEN(PULSE_LEN)) u_sys (
    .clk(clk), .rst(rst), .trig(sys_evt), .pulse(sys_rst_o)
  );

  // registered read port; soft request offsets read as zero
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      if      (rd_addr == ADDR_W'(OFS_WDOG))  rd_data <= {7'b0, wd_en};
      else if (rd_addr == ADDR_W'(OFS_MASK))  rd_data <= {fe_mask, 4'b0};
      else if (rd_addr == ADDR_W'(OFS_SYNTH)) rd_data <= {syn_rst, 6'b0, syn_load};
      else if (rd_addr == ADDR_W'(OFS_PLOG0)) rd_data <= por_log[7:0];
      else if (rd_addr == ADDR_W'(OFS_PLOG1)) rd_data <= por_log[15:8];
      else if (rd_addr == ADDR_W'(OFS_PLOG2)) rd_data <= {6'b0, por_log[17:16]};
      else if (rd_addr == ADDR_W'(OFS_XLOG))  rd_data <= {2'b0, xir_log};
    end
  end
endmodule

// File: rtl/reset_cause_ctl_chk.sv
module reset_cause_ctl_chk
  import reset_cause_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int PULSE_LEN = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              wdog_i,
  input logic              wd_en,
  input logic [NCPU-1:0]   por_o,
  input logic [NCPU-1:0]   xir_o,
  input logic              sys_rst_o
);
  int hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)            hi_cnt <= 0;
    else if (sys_rst_o) hi_cnt <= (hi_cnt < PULSE_LEN) ? hi_cnt + 1 : hi_cnt;
    else                hi_cnt <= 0;
  end

  // R2: requested per-CPU POR bits are high next cycle
  a_r2_soft_por: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(OFS_SPOR))
      |=> ((por_o & $past(wr_data[NCPU-1:0])) == $past(wr_data[NCPU-1:0])));

  // R4: requested per-CPU XIR bits are high next cycle
  a_r4_soft_xir: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(OFS_SXIR))
      |=> ((xir_o & $past(wr_data[NCPU-1:0])) == $past(wr_data[NCPU-1:0])));

  // R3: a system reset holds every CPU in POR
  a_r3_sys_all_cpus: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |-> (&por_o));

  // R3: a system pulse lasts at least the configured length
  a_r3_min_len: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst_o) |-> (hi_cnt >= PULSE_LEN));

  // R6: enabled watchdog edge leads to system reset
  a_r6_wdog_reset: assert property (@(posedge clk) disable iff (rst)
    ($rose(wdog_i) && wd_en) |=> sys_rst_o);
endmodule

bind reset_cause_ctl reset_cause_ctl_chk #(
  .ADDR_W(ADDR_W), .PULSE_LEN(PULSE_LEN)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .wdog_i(wdog_i), .wd_en(wd_en), .por_o(por_o), .xir_o(xir_o),
  .sys_rst_o(sys_rst_o)
);

// File: tb/reset_cause_ctl_test.sv
module reset_cause_ctl_test;
  localparam int AW = 4;
  localparam int PL = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic wdog_i = 0, jtag_rst_i = 0, jtag_xir_i = 0, por_btn_i = 0;
  logic xir_btn_i = 0, rmon_i = 0;
  logic [6:0] fatal_i = '0;
  logic [3:0] por_o, xir_o;
  logic       sys_rst_o;

  int vectors = 0;
  int misses  = 0;
  logic [17:0] exp_plog;

  always #2 clk = ~clk;

  reset_cause_ctl #(.ADDR_W(AW), .PULSE_LEN(PL)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wdog_i(wdog_i),
    .jtag_rst_i(jtag_rst_i), .jtag_xir_i(jtag_xir_i), .por_btn_i(por_btn_i),
    .xir_btn_i(xir_btn_i), .rmon_i(rmon_i), .fatal_i(fatal_i),
    .por_o(por_o), .xir_o(xir_o), .sys_rst_o(sys_rst_o)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_byte(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic read_plog(output logic [17:0] v);
    logic [7:0] b0, b1, b2;
    read_byte(4'h8, b0);
    read_byte(4'h9, b1);
    read_byte(4'hA, b2);
    v = {b2[1:0], b1, b0};
  endtask

  // count consecutive negedges where the selected output is high
  function automatic logic sel_sig(input int s);
    case (s)
      0: return sys_rst_o;
      1: return |por_o;
      default: return |xir_o;
    endcase
  endfunction

  task automatic measure(input int s, output int n);
    n = 0;
    while (sel_sig(s) && n < 40) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [17:0] pl;
    int n;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 por_o", por_o, 0);
    check("R1 xir_o", xir_o, 0);
    check("R1 sys", sys_rst_o, 0);
    read_plog(pl);   check("R1 por log", pl, 18'h80);
    read_byte(4'hC, b); check("R1 xir log", b, 0);
    read_byte(4'h0, b); check("R1 wdog ctl", b, 0);
    read_byte(4'h3, b); check("R1 mask", b, 0);
    read_byte(4'h4, b); check("R1 synth", b, 0);
    exp_plog = 18'h80;

    // R2 soft POR sweep
    for (int v = 1; v < 16; v++) begin
      do_write(4'h1, 8'(v));
      check("R2 por pattern", por_o, v);
      check("R2 no sys", sys_rst_o, 0);
      measure(1, n);
      check("R2 por length", n, PL);
      exp_plog = 18'(v);
      read_plog(pl); check("R2 por log", pl, exp_plog);
      read_byte(4'h1, b); check("R2 self clear", b, 0);
    end

    // R3 system soft reset
    do_write(4'h1, 8'h10);
    check("R3 all por", por_o, 4'hF);
    measure(0, n);
    check("R3 sys length", n, PL);
    exp_plog = 18'h10;
    read_plog(pl); check("R3 por log", pl, exp_plog);

    // R10 simultaneous causes
    do_write(4'h1, 8'h13);
    wait_cyc(10);
    exp_plog = 18'h13;
    read_plog(pl); check("R10 multi cause", pl, exp_plog);

    // R4 soft XIR sweep
    for (int v = 1; v < 16; v++) begin
      do_write(4'h2, 8'(v));
      check("R4 xir pattern", xir_o, v);
      check("R4 no por", por_o, 0);
      measure(2, n);
      check("R4 xir length", n, PL);
      read_byte(4'hC, b); check("R4 xir log", b, v);
      read_byte(4'h2, b); check("R4 self clear", b, 0);
      read_plog(pl); check("R4 por log kept", pl, exp_plog);
    end

    // R5 JTAG XIR and XIR button
    @(negedge clk); jtag_xir_i = 1; @(negedge clk); jtag_xir_i = 0;
    check("R5 jtag xir all", xir_o, 4'hF);
    measure(2, n); check("R5 jtag xir length", n, PL);
    read_byte(4'hC, b); check("R5 jtag xir log", b, 8'h10);
    @(negedge clk); xir_btn_i = 1; @(negedge clk); xir_btn_i = 0;
    check("R5 button xir all", xir_o, 4'hF);
    wait_cyc(10);
    read_byte(4'hC, b); check("R5 button xir log", b, 8'h20);

    // R6 watchdog disabled then enabled
    @(negedge clk); wdog_i = 1; @(negedge clk); wdog_i = 0;
    check("R6 disabled no sys", sys_rst_o, 0);
    check("R6 disabled no por", por_o, 0);
    read_plog(pl); check("R6 disabled log", pl, exp_plog);
    do_write(4'h0, 8'h01);
    read_byte(4'h0, b); check("R6 ctl readback", b, 1);
    @(negedge clk); wdog_i = 1; @(negedge clk); wdog_i = 0;
    measure(0, n); check("R6 wdog sys length", n, PL);
    exp_plog = 18'h10000;
    read_plog(pl); check("R6 wdog log", pl, exp_plog);
    do_write(4'h0, 8'h00);

    // R7 external sources
    @(negedge clk); jtag_rst_i = 1; @(negedge clk); jtag_rst_i = 0;
    check("R7 jtag sys", sys_rst_o, 1);
    wait_cyc(10);
    read_plog(pl); check("R7 jtag log", pl, 18'h20);
    @(negedge clk); por_btn_i = 1; @(negedge clk); por_btn_i = 0;
    check("R7 button sys", sys_rst_o, 1);
    wait_cyc(10);
    read_plog(pl); check("R7 button log", pl, 18'h40);
    @(negedge clk); rmon_i = 1; @(negedge clk); rmon_i = 0;
    check("R7 remote sys", sys_rst_o, 1);
    wait_cyc(10);
    exp_plog = 18'h20000;
    read_plog(pl); check("R7 remote log", pl, exp_plog);

    // R8 fatal inputs under every mask
    for (int m = 0; m < 16; m++) begin
      do_write(4'h3, 8'(m << 4));
      read_byte(4'h3, b); check("R8 mask readback", b, m << 4);
      for (int i = 0; i < 7; i++) begin
        bit fire;
        fire = !(i < 4 && m[i]);
        @(negedge clk); fatal_i[i] = 1; @(negedge clk); fatal_i[i] = 0;
        check("R8 fatal reset", sys_rst_o, fire);
        wait_cyc(10);
        if (fire) exp_plog = 18'(1) << (8 + i);
        read_plog(pl); check("R8 fatal log", pl, exp_plog);
      end
    end
    do_write(4'h3, 8'h00);

    // R9 synthesizer load
    do_write(4'h4, 8'h01);
    check("R9 load only no sys", sys_rst_o, 0);
    do_write(4'h4, 8'h80);
    check("R9 enable only no sys", sys_rst_o, 0);
    read_plog(pl); check("R9 no log change", pl, exp_plog);
    do_write(4'h4, 8'h81);
    check("R9 synth sys", sys_rst_o, 1);
    wait_cyc(10);
    exp_plog = 18'h8000;
    read_plog(pl); check("R9 synth log", pl, exp_plog);
    read_byte(4'h4, b); check("R9 readback", b, 8'h81);

    // R10 log is read-only
    do_write(4'h8, 8'hFF);
    do_write(4'h9, 8'hFF);
    do_write(4'hA, 8'hFF);
    check("R10 no pulse", sys_rst_o, 0);
    read_plog(pl); check("R10 log ignores writes", pl, exp_plog);

    // R11 retrigger restarts the count
    do_write(4'h1, 8'h01);
    wait_cyc(3);
    check("R11 still high", por_o, 1);
    do_write(4'h1, 8'h01);
    measure(1, n); check("R11 restarted length", n, PL);

    // R12 held input yields one event
    @(negedge clk); jtag_rst_i = 1;
    @(negedge clk);
    measure(0, n); check("R12 held length", n, PL);
    wait_cyc(12);
    check("R12 no repeat", sys_rst_o, 0);
    jtag_rst_i = 0;
    wait_cyc(2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule